// File: doc/BRIEF.md
# Clock and Reset Controller Register Bank

This block holds the control and status words of a clock and reset controller. Software reaches it through a 32-bit APB-style slave port with a 4 KiB address window. Nine registers are mapped in that window. One holds the crystal oscillator settings. Five configure three PLLs: the core PLL, the DDR PLL and the Ethernet PLL. The others hold the core clock source select, the per-device reset lines and a clock-mux status word. Every register is also driven out on its own flat 32-bit port, so the clock and reset logic around the block can use the contents directly.

No oscillator, PLL or clock switch sits behind the registers. For that reason the ready and lock flags that boot firmware polls are held high by hardware. Each write to the oscillator register or to a PLL primary configuration register sets those flags again, along with the PLL internal-feedback select. The power-on values place each PLL at a known divider setting. They also select the high-frequency reference as the core clock.

Top module: `ckrc_regs`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the registers hold these values:
  - oscillator 0xC000_0000
  - the three PLL primary words 0x8201_87C1 (divr=1 at bits 5:0, divf=31 at bits 14:6, divq=3 at bits 17:15, feedback bit 25, lock bit 31)
  - core clock select 0x0000_0001
  - every other register 0
- R2: A write to offset 0x00 (oscillator) stores the written word with bit 31 (ready) forced to 1. Bit 30 is the enable bit and is stored as written.
- R3: A write to offset 0x04, 0x0C or 0x1C (core, DDR and Ethernet PLL primary words) stores the written word with bits 25 and 31 forced to 1.
- R4: Writes to the following offsets store the full written word unmodified:
  - 0x10 and 0x20 (DDR and Ethernet PLL secondary words, clock enable at bit 24)
  - 0x24 (core clock select)
  - 0x28 (device resets)
  - 0x2C (clock-mux status)
- R5: A read with `psel` and `penable` high returns the addressed register on `prdata` within that access cycle. `pready` is always 1.
- R6: An access to an offset inside the window that is not one of the nine mapped offsets raises `pslverr` in its access phase and returns `prdata` = 0. If it is a write, no register changes.
- R7: An access with `psize` other than 2 (word; 0 = byte, 1 = halfword), or with `paddr[1:0]` non-zero, raises `pslverr`, returns `prdata` = 0 and changes no register.
- R8: A read issued in the transfer right after a write returns the written word with the forced bits already set.
- R9: A register changes only at the clock edge that ends an error-free write access phase. A setup phase alone changes nothing. Each output port equals the register that reads back at its offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte offset within the window |
| psize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error in the access phase |
| osc_cfg | output | 32 | Oscillator register |
| core_pll_cfg0 | output | 32 | Core PLL primary word |
| ddr_pll_cfg0 | output | 32 | DDR PLL primary word |
| ddr_pll_cfg1 | output | 32 | DDR PLL secondary word |
| eth_pll_cfg0 | output | 32 | Ethernet PLL primary word |
| eth_pll_cfg1 | output | 32 | Ethernet PLL secondary word |
| core_clk_sel | output | 32 | Core clock source select |
| dev_reset | output | 32 | Per-device reset lines |
| clkmux_status | output | 32 | Clock-mux status word |

## Verification
`prdata` and `pslverr` are combinational from the decode and the stored registers, so they are due in the access-phase cycle itself. The bench drives each phase on a falling edge and samples them shortly after the falling edge that starts the access phase. A write lands at the rising edge that ends its access phase, so the register ports and any read-back are due from the next cycle on. The bench checks written contents with a separate read transfer, and checks the output ports only after the transfer has closed. Setup-only and error cases are judged one full cycle after their would-be commit edge.

// File: rtl/ckrc_pkg.sv
package ckrc_pkg;

  localparam int NREG   = 9;
  localparam int REG_W  = 32;
  localparam int OFF_W  = 12;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [3:0] {
    IX_OSC    = 4'd0,
    IX_CPLL0  = 4'd1,
    IX_DPLL0  = 4'd2,
    IX_DPLL1  = 4'd3,
    IX_EPLL0  = 4'd4,
    IX_EPLL1  = 4'd5,
    IX_CSEL   = 4'd6,
    IX_DEVRST = 4'd7,
    IX_MUXST  = 4'd8
  } reg_ix_e;

  // Bit positions shared by all PLL primary words
  localparam int PLL_FB_BIT   = 25;
  localparam int PLL_LOCK_BIT = 31;
  localparam int OSC_RDY_BIT  = 31;
  localparam int OSC_EN_BIT   = 30;

  localparam logic [REG_W-1:0] PLL0_FORCE =
    (REG_W'(1) << PLL_FB_BIT) | (REG_W'(1) << PLL_LOCK_BIT);
  localparam logic [REG_W-1:0] PLL0_INIT =
    REG_W'(1) | (REG_W'(31) << 6) | (REG_W'(3) << 15) | PLL0_FORCE;
  localparam logic [REG_W-1:0] OSC_FORCE = REG_W'(1) << OSC_RDY_BIT;
  localparam logic [REG_W-1:0] OSC_INIT  = OSC_FORCE | (REG_W'(1) << OSC_EN_BIT);

  function automatic logic [OFF_W-1:0] reg_offset(input int ix);
    case (ix)
      0:       return 12'h000;
      1:       return 12'h004;
      2:       return 12'h00C;
      3:       return 12'h010;
      4:       return 12'h01C;
      5:       return 12'h020;
      6:       return 12'h024;
      7:       return 12'h028;
      default: return 12'h02C;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_init(input int ix);
    case (ix)
      0:          return OSC_INIT;
      1, 2, 4:    return PLL0_INIT;
      6:          return REG_W'(1);
      default:    return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_force(input int ix);
    case (ix)
      0:          return OSC_FORCE;
      1, 2, 4:    return PLL0_FORCE;
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/ckrc_decode.sv
module ckrc_decode
  import ckrc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic [1:0]        psize,
  output logic [NREG-1:0]   hit,
  output logic              bad
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (paddr == ADDR_W'(reg_offset(i)));
  end

  // word size, word alignment and a mapped offset are all required
  assign bad = (psize != SIZE_WORD) || (paddr[1:0] != 2'b00) || (hit == '0);
endmodule

// File: rtl/ckrc_reg.sv
module ckrc_reg #(
  parameter int              W     = 32,
  parameter logic [W-1:0]    INIT  = '0,
  parameter logic [W-1:0]    FORCE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= INIT;
    else if (we) q <= wd | FORCE;
  end
endmodule

// File: rtl/ckrc_rdmux.sv
module ckrc_rdmux
  import ckrc_pkg::*;
(
  input  logic [NREG-1:0]  sel,
  input  logic [REG_W-1:0] regs [NREG],
  output logic [REG_W-1:0] rd
);
  always_comb begin
    rd = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rd = rd | regs[i];
  end
endmodule

// File: rtl/ckrc_regs.sv
module ckrc_regs
  import ckrc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [1:0]        psize,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [31:0]       osc_cfg,
  output logic [31:0]       core_pll_cfg0,
  output logic [31:0]       ddr_pll_cfg0,
  output logic [31:0]       ddr_pll_cfg1,
  output logic [31:0]       eth_pll_cfg0,
  output logic [31:0]       eth_pll_cfg1,
  output logic [31:0]       core_clk_sel,
  output logic [31:0]       dev_reset,
  output logic [31:0]       clkmux_status
);
  logic [NREG-1:0]  hit;
  logic             bad;
  logic             access;
  logic [REG_W-1:0] q [NREG];
  logic [REG_W-1:0] rd;
  logic [NREG-1:0]  rsel;

  ckrc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .paddr (paddr),
    .psize (psize),
    .hit   (hit),
    .bad   (bad)
  );

  assign access = psel && penable;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    ckrc_reg #(
      .W     (REG_W),
      .INIT  (reg_init(i)),
      .FORCE (reg_force(i))
    ) u_reg (
      .clk (clk),
      .rst (rst),
      .we  (access && pwrite && !bad && hit[i]),
      .wd  (pwdata),
      .q   (q[i])
    );
  end

  assign rsel = (access && !pwrite && !bad) ? hit : '0;

  ckrc_rdmux u_mux (
    .sel  (rsel),
    .regs (q),
    .rd   (rd)
  );

  assign prdata  = rd;
  assign pready  = 1'b1;
  assign pslverr = access && bad;

  assign osc_cfg       = q[IX_OSC];
  assign core_pll_cfg0 = q[IX_CPLL0];
  assign ddr_pll_cfg0  = q[IX_DPLL0];
  assign ddr_pll_cfg1  = q[IX_DPLL1];
  assign eth_pll_cfg0  = q[IX_EPLL0];
  assign eth_pll_cfg1  = q[IX_EPLL1];
  assign core_clk_sel  = q[IX_CSEL];
  assign dev_reset     = q[IX_DEVRST];
  assign clkmux_status = q[IX_MUXST];
endmodule

// File: rtl/ckrc_regs_chk.sv
module ckrc_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [1:0]        psize,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [31:0]       osc_cfg,
  input logic [31:0]       core_pll_cfg0,
  input logic [31:0]       ddr_pll_cfg0,
  input logic [31:0]       ddr_pll_cfg1,
  input logic [31:0]       eth_pll_cfg0,
  input logic [31:0]       eth_pll_cfg1,
  input logic [31:0]       core_clk_sel,
  input logic [31:0]       dev_reset,
  input logic [31:0]       clkmux_status
);
  logic [32*9-1:0] all_regs;
  assign all_regs = {osc_cfg, core_pll_cfg0, ddr_pll_cfg0, ddr_pll_cfg1,
                     eth_pll_cfg0, eth_pll_cfg1, core_clk_sel, dev_reset, clkmux_status};

  AST_OSC_READY: assert property (@(posedge clk) disable iff (rst)
    osc_cfg[31]); // R2

  AST_PLL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    core_pll_cfg0[31] && core_pll_cfg0[25] && ddr_pll_cfg0[31] && ddr_pll_cfg0[25]
    && eth_pll_cfg0[31] && eth_pll_cfg0[25]); // R3

  AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (rst)
    psel && penable && pwrite && !pslverr && paddr == ADDR_W'(12'h024) && psize == 2'd2
    |=> core_clk_sel == $past(pwdata)); // R4

  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
    pready); // R5

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    psel && penable && pslverr |=> $stable(all_regs)); // R6

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> prdata == 32'h0); // R6

  AST_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
    psel && penable && (psize != 2'd2 || paddr[1:0] != 2'b00) |-> pslverr); // R7

  AST_SETUP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable) |=> $stable(all_regs)); // R9
endmodule

bind ckrc_regs ckrc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ckrc_regs.sv
`timescale 1ns/1ps
module tb_ckrc_regs;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [1:0]        psize;
  logic [31:0]       pwdata;
  logic [31:0]       prdata;
  logic              pready, pslverr;
  logic [31:0] osc_cfg, core_pll_cfg0, ddr_pll_cfg0, ddr_pll_cfg1, eth_pll_cfg0;
  logic [31:0] eth_pll_cfg1, core_clk_sel, dev_reset, clkmux_status;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ckrc_regs #(.ADDR_W(ADDR_W)) dut (.*);

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 2'd2, 32'h0,          32'hC000_0000, 1'b0, 4'd1}, // R1
    '{1'b0, 12'h004, 2'd2, 32'h0,          32'h8201_87C1, 1'b0, 4'd1}, // R1
    '{1'b0, 12'h00C, 2'd2, 32'h0,          32'h8201_87C1, 1'b0, 4'd1}, // R1
    '{1'b0, 12'h01C, 2'd2, 32'h0,          32'h8201_87C1, 1'b0, 4'd1}, // R1
    '{1'b0, 12'h024, 2'd2, 32'h0,          32'h0000_0001, 1'b0, 4'd1}, // R1
    '{1'b0, 12'h010, 2'd2, 32'h0,          32'h0000_0000, 1'b0, 4'd1}, // R1
    '{1'b1, 12'h000, 2'd2, 32'h0000_1234,  32'h0,         1'b0, 4'd2}, // R2
    '{1'b0, 12'h000, 2'd2, 32'h0,          32'h8000_1234, 1'b0, 4'd8}, // R8
    '{1'b1, 12'h004, 2'd2, 32'h0000_0000,  32'h0,         1'b0, 4'd3}, // R3
    '{1'b0, 12'h004, 2'd2, 32'h0,          32'h8200_0000, 1'b0, 4'd3}, // R3
    '{1'b1, 12'h00C, 2'd2, 32'h1234_5678,  32'h0,         1'b0, 4'd3}, // R3
    '{1'b0, 12'h00C, 2'd2, 32'h0,          32'h9234_5678, 1'b0, 4'd3}, // R3
    '{1'b1, 12'h01C, 2'd2, 32'h0000_0040,  32'h0,         1'b0, 4'd3}, // R3
    '{1'b0, 12'h01C, 2'd2, 32'h0,          32'h8200_0040, 1'b0, 4'd8}, // R8
    '{1'b1, 12'h010, 2'd2, 32'h8100_00FF,  32'h0,         1'b0, 4'd4}, // R4
    '{1'b0, 12'h010, 2'd2, 32'h0,          32'h8100_00FF, 1'b0, 4'd4}, // R4
    '{1'b1, 12'h020, 2'd2, 32'h0100_0000,  32'h0,         1'b0, 4'd4}, // R4
    '{1'b0, 12'h020, 2'd2, 32'h0,          32'h0100_0000, 1'b0, 4'd4}, // R4
    '{1'b1, 12'h024, 2'd2, 32'h0000_0000,  32'h0,         1'b0, 4'd4}, // R4
    '{1'b0, 12'h024, 2'd2, 32'h0,          32'h0000_0000, 1'b0, 4'd4}, // R4
    '{1'b1, 12'h028, 2'd2, 32'hDEAD_BEEF,  32'h0,         1'b0, 4'd4}, // R4
    '{1'b0, 12'h028, 2'd2, 32'h0,          32'hDEAD_BEEF, 1'b0, 4'd5}, // R5
    '{1'b1, 12'h02C, 2'd2, 32'h7000_0003,  32'h0,         1'b0, 4'd4}, // R4
    '{1'b0, 12'h008, 2'd2, 32'h0,          32'h0,         1'b1, 4'd6}, // R6
    '{1'b0, 12'hFFC, 2'd2, 32'h0,          32'h0,         1'b1, 4'd6}  // R6
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // one APB transfer; prdata/pslverr captured in the access phase
  task automatic xfer(input logic wr, input logic [11:0] addr, input logic [1:0] size,
                      input logic [31:0] wd, output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; psize = size; pwdata = wd;
    @(negedge clk);
    penable = 1'b1;
    #0.5;
    rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    logic [31:0] snap;
    rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; psize = 2'd2; pwdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state at the ports
    check("R1", "osc_cfg", osc_cfg, 32'hC000_0000);
    check("R1", "ddr_pll_cfg0", ddr_pll_cfg0, 32'h8201_87C1);
    check("R1", "dev_reset", dev_reset, 32'h0);
    check("R5", "pready", {31'h0, pready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].wdata, rd, err);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d err", i), {31'h0, err}, {31'h0, VEC[i].err});
      if (!VEC[i].wr)
        check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rdata", i), rd, VEC[i].exp);
    end

    // R9 output ports mirror stored contents
    check("R9", "clkmux_status", clkmux_status, 32'h7000_0003);
    check("R9", "eth_pll_cfg0", eth_pll_cfg0, 32'h8200_0040);
    check("R9", "core_pll_cfg0", core_pll_cfg0, 32'h8200_0000);

    // R6 unmapped write in the window leaves every register unchanged
    xfer(1'b1, 12'h014, 2'd2, 32'hFFFF_FFFF, rd, err);
    check("R6", "unmapped write err", {31'h0, err}, 32'h1);
    xfer(1'b0, 12'h010, 2'd2, 32'h0, rd, err);
    check("R6", "neighbour after unmapped write", rd, 32'h8100_00FF);
    check("R6", "eth_pll_cfg1 port", eth_pll_cfg1, 32'h0100_0000);

    // R7 halfword write rejected, byte read rejected, misaligned rejected
    xfer(1'b1, 12'h024, 2'd1, 32'h0000_0005, rd, err);
    check("R7", "halfword write err", {31'h0, err}, 32'h1);
    @(negedge clk);
    check("R7", "core_clk_sel after halfword write", core_clk_sel, 32'h0);
    xfer(1'b0, 12'h028, 2'd0, 32'h0, rd, err);
    check("R7", "byte read err", {31'h0, err}, 32'h1);
    check("R7", "byte read data", rd, 32'h0);
    xfer(1'b1, 12'h02A, 2'd2, 32'h1, rd, err);
    check("R7", "misaligned write err", {31'h0, err}, 32'h1);
    check("R7", "clkmux_status after misaligned", clkmux_status, 32'h7000_0003);

    // R9 setup phase without access phase does not write
    snap = dev_reset;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h028; psize = 2'd2; pwdata = 32'h0;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    check("R9", "dev_reset after setup-only", dev_reset, snap);

    // R2 enable bit clearable, ready bit not
    xfer(1'b1, 12'h000, 2'd2, 32'h0000_0000, rd, err);
    @(negedge clk);
    check("R2", "osc_cfg cleared write", osc_cfg, 32'h8000_0000);

    // R1 reset mid-run restores power-on values
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "osc_cfg after reset", osc_cfg, 32'hC000_0000);
    check("R1", "core_clk_sel after reset", core_clk_sel, 32'h1);
    check("R1", "ddr_pll_cfg1 after reset", ddr_pll_cfg1, 32'h0);
    check("R1", "eth_pll_cfg0 after reset", eth_pll_cfg0, 32'h8201_87C1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule